// File: doc/BRIEF.md
# Dual-Threshold Photon Counting Pixel Back End

This block is the digital back end of one photon-counting pixel. Two discriminated hit pulses arrive from outside the clock domain. One comes from a low-threshold comparator and the other from a high-threshold comparator. Each hit line passes through its own synchronizer and rising-edge detector, and then drives its own saturating 14-bit event counter. The high-threshold count therefore follows photons above the upper energy, and the low-threshold count follows all photons above the lower energy.

A frame-latch strobe copies both live counts and their overflow flags into shadow registers. In the same clock edge the live counters restart, so counting goes on while the previous frame is read out and no dead time appears between frames. The same edge also stores an energy-window count, which is the low count minus the high count, clamped at zero. A counter enable lets the surrounding logic freeze counting without losing the counts already taken.

The shadow outputs are plain registers. They hold their value until the next latch. There is no handshake: a reader samples them at any time between two strobes, so there is no back-pressure to respect.

Top module: `pxl_dual_counter`

## Requirements
- R1: After reset, all shadow outputs (both counts, the window count and both overflow flags) read zero.
- R2: Each pulse on the low hit input counts exactly one, however many cycles the pulse stays high. The count is taken on the third rising clock edge after the input rises.
- R3: The high hit input drives its own counter. That counter is fully independent of the low counter, including for pulses that arrive on both inputs in the same cycle.
- R4: While the counter enable is low, hit pulses are ignored and both live counts hold their value. Counting resumes from the held value once the enable returns high.
- R5: On a clock edge with the frame latch high, both shadow counts take the live counts as they stood just before that edge. The shadows then hold until the next latch.
- R6: On a latch edge, each live counter restarts at 0. If a counted hit edge falls on that same clock edge, the counter restarts at 1, so the hit goes into the new frame.
- R7: A counter stops at 16383 and never wraps.
- R8: A per-counter overflow flag is set when a counted hit arrives while the counter already holds 16383. Reaching exactly 16383 does not set it. The flag is copied to its shadow output on the latch edge and is cleared for the new frame.
- R9: On the latch edge, the window output takes the low count minus the high count. It takes 0 when the high count is larger.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Counting enable; when low, hits are ignored and counts hold |
| hit_lo | input | 1 | Asynchronous hit pulse from the low-threshold comparator |
| hit_hi | input | 1 | Asynchronous hit pulse from the high-threshold comparator |
| frame_latch | input | 1 | Strobe that moves the live counts to the shadows and restarts counting |
| lo_count | output | 14 | Shadow copy of the low-threshold count |
| hi_count | output | 14 | Shadow copy of the high-threshold count |
| win_count | output | 14 | Shadow energy-window count, low minus high, clamped at 0 |
| lo_ovf | output | 1 | Shadow overflow flag of the low counter |
| hi_ovf | output | 1 | Shadow overflow flag of the high counter |

## Verification
A hit that goes high before rising edge E0 is counted at edge E2. That is two synchronizer flops plus the counter register. The shadows and the window change on the very edge where the latch is high.

The bench therefore always leaves at least four idle cycles after the last pulse before it strobes the latch. It reads the outputs on the falling edge after the latch edge.

The hit-on-latch case is placed on purpose. The pulse is raised two falling edges before the latch, so its counted edge lands exactly on the latch edge.

// File: rtl/pxl_cnt_pkg.sv
package pxl_cnt_pkg;
  typedef enum logic [0:0] {
    THR_LO = 1'b0,
    THR_HI = 1'b1
  } thr_e;

  localparam int NUM_THR = 2;
endpackage

// File: rtl/pxl_hit_sync.sv
module pxl_hit_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_async,
  output logic hit_rise
);
  // SYNC_STAGES synchronizer flops plus one history flop for edge detection
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], hit_async};
  end

  assign hit_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

  // one edge per pulse: a detected edge is never followed by another at once
  AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_rise |=> !hit_rise); // R2
endmodule

// File: rtl/pxl_sat_counter.sv
module pxl_sat_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q
);
  localparam logic [CNT_W-1:0] MAX_CNT = {CNT_W{1'b1}};

  logic step;
  logic at_max;

  assign step   = en & inc;
  assign at_max = (count_q == MAX_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
    end else if (clr) begin
      count_q <= CNT_W'(step);
      ovf_q   <= 1'b0;
    end else if (step) begin
      if (at_max) ovf_q   <= 1'b1;
      else        count_q <= count_q + 1'b1;
    end
  end

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((count_q - $past(count_q)) <= CNT_W'(1))); // R2
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && count_q == MAX_CNT) |=> (count_q == MAX_CNT)); // R7
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(count_q)); // R4
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_q <= CNT_W'(1) && !ovf_q)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr) |=> ovf_q); // R8
endmodule

// File: rtl/pxl_dual_counter.sv
module pxl_dual_counter
  import pxl_cnt_pkg::*;
#(
  parameter int CNT_W       = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             hit_lo,
  input  logic             hit_hi,
  input  logic             frame_latch,
  output logic [CNT_W-1:0] lo_count,
  output logic [CNT_W-1:0] hi_count,
  output logic [CNT_W-1:0] win_count,
  output logic             lo_ovf,
  output logic             hi_ovf
);
  localparam int LO = int'(THR_LO);
  localparam int HI = int'(THR_HI);

  logic [NUM_THR-1:0] hit_in;
  logic [NUM_THR-1:0] hit_edge;
  logic [NUM_THR-1:0] ovf_live;
  logic [CNT_W-1:0]   live_cnt [NUM_THR];
  logic [CNT_W-1:0]   win_next;

  assign hit_in[LO] = hit_lo;
  assign hit_in[HI] = hit_hi;

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    pxl_hit_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit_async (hit_in[t]),
      .hit_rise  (hit_edge[t])
    );

    pxl_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (cnt_en),
      .inc     (hit_edge[t]),
      .clr     (frame_latch),
      .count_q (live_cnt[t]),
      .ovf_q   (ovf_live[t])
    );
  end

  assign win_next = (live_cnt[LO] > live_cnt[HI]) ? (live_cnt[LO] - live_cnt[HI]) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_count  <= '0;
      hi_count  <= '0;
      win_count <= '0;
      lo_ovf    <= 1'b0;
      hi_ovf    <= 1'b0;
    end else if (frame_latch) begin
      lo_count  <= live_cnt[LO];
      hi_count  <= live_cnt[HI];
      win_count <= win_next;
      lo_ovf    <= ovf_live[LO];
      hi_ovf    <= ovf_live[HI];
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_latch |=> ($stable(lo_count) && $stable(hi_count) && $stable(win_count))); // R5
  AST_SHADOW_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_latch |=> (lo_count == $past(live_cnt[LO]) && hi_count == $past(live_cnt[HI]))); // R5
  AST_WIN_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_count >= hi_count) |-> (win_count + hi_count == lo_count)); // R9
  AST_WIN_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_count > lo_count) |-> (win_count == '0)); // R9
endmodule

// File: tb/pxl_dual_counter_tb.sv
module pxl_dual_counter_tb;
  localparam int W = 14;
  localparam int MAXC = (1 << W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0;
  logic hit_lo = 1'b0;
  logic hit_hi = 1'b0;
  logic frame_latch = 1'b0;
  logic [W-1:0] lo_count, hi_count, win_count;
  logic lo_ovf, hi_ovf;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  pxl_dual_counter #(.CNT_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .hit_lo(hit_lo), .hit_hi(hit_hi),
    .frame_latch(frame_latch), .lo_count(lo_count), .hi_count(hi_count),
    .win_count(win_count), .lo_ovf(lo_ovf), .hi_ovf(hi_ovf)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic pulse(input bit lo, input bit hi);
    @(negedge clk); hit_lo = lo; hit_hi = hi;
    @(negedge clk); hit_lo = 1'b0; hit_hi = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic latch();
    @(negedge clk); frame_latch = 1'b1;
    @(negedge clk); frame_latch = 1'b0;
  endtask

  task automatic frame(input int nlo, input int nhi);
    int most;
    most = (nlo > nhi) ? nlo : nhi;
    for (int i = 0; i < most; i++) pulse(i < nlo, i < nhi);
    settle();
    latch();
  endtask

  function automatic int win_of(input int a, input int b);
    return (a > b) ? a - b : 0;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 lo_count", int'(lo_count), 0);
    chk("R1 hi_count", int'(hi_count), 0);
    chk("R1 win_count", int'(win_count), 0);
    chk("R1 ovf", int'({lo_ovf, hi_ovf}), 0);
    rst_n = 1'b1;
    cnt_en = 1'b1;
    settle();
    latch();

    // R2 R3 R9 sweep of pulse counts on both thresholds
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        frame(a, b);
        chk($sformatf("R2 lo a=%0d b=%0d", a, b), int'(lo_count), a);
        chk($sformatf("R3 hi a=%0d b=%0d", a, b), int'(hi_count), b);
        chk($sformatf("R9 win a=%0d b=%0d", a, b), int'(win_count), win_of(a, b));
      end
    end

    // R2 a long pulse still counts once
    @(negedge clk); hit_lo = 1'b1;
    repeat (10) @(negedge clk);
    hit_lo = 1'b0;
    settle();
    latch();
    chk("R2 long pulse", int'(lo_count), 1);

    // R4 enable low ignores hits and holds the count
    frame(0, 0);
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    settle();
    @(negedge clk); cnt_en = 1'b0;
    for (int i = 0; i < 5; i++) pulse(1, 1);
    settle();
    @(negedge clk); cnt_en = 1'b1;
    pulse(1, 0); pulse(1, 0);
    settle();
    latch();
    chk("R4 lo held", int'(lo_count), 5);
    chk("R4 hi ignored", int'(hi_count), 0);

    // R5 shadows hold between latches
    repeat (6) pulse(1, 1);
    settle();
    chk("R5 lo stable", int'(lo_count), 5);
    chk("R5 hi stable", int'(hi_count), 0);
    latch();
    chk("R5 lo new", int'(lo_count), 6);

    // R6 hit edge landing on the latch edge goes into the new frame
    pulse(1, 0); pulse(1, 0); pulse(1, 0);
    settle();
    @(negedge clk); hit_lo = 1'b1; hit_hi = 1'b1;
    @(negedge clk); hit_lo = 1'b0; hit_hi = 1'b0;
    @(negedge clk); frame_latch = 1'b1;
    @(negedge clk); frame_latch = 1'b0;
    chk("R6 lo old frame", int'(lo_count), 3);
    chk("R6 hi old frame", int'(hi_count), 0);
    settle();
    latch();
    chk("R6 lo restart one", int'(lo_count), 1);
    chk("R6 hi restart one", int'(hi_count), 1);

    // R7 R8 exactly full: no overflow
    for (int i = 0; i < MAXC; i++) pulse(1, 0);
    settle();
    latch();
    chk("R7 lo at max", int'(lo_count), MAXC);
    chk("R8 no flag at max", int'(lo_ovf), 0);

    // R7 R8 beyond full: saturate and flag
    for (int i = 0; i < MAXC + 2; i++) pulse(1, i < 100);
    settle();
    latch();
    chk("R7 lo saturated", int'(lo_count), MAXC);
    chk("R8 lo flag", int'(lo_ovf), 1);
    chk("R8 hi flag", int'(hi_ovf), 0);
    chk("R9 win large", int'(win_count), MAXC - 100);

    // R8 flag cleared for the next frame
    frame(2, 0);
    chk("R8 flag cleared", int'(lo_ovf), 0);
    chk("R8 count after clear", int'(lo_count), 2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule